// File: doc/BRIEF.md
# Program Memory Byte Table Reader

This block lets software fetch single bytes out of a program memory that is organised as 16-bit words. A 21-bit byte pointer is kept in three byte-wide pieces that software can load one at a time. A table-read command sends the word address to the memory, selects one half of the returned word, and places that byte in an 8-bit result latch.

Each command carries a 2-bit adjust code. The pointer can stay put or move by one byte. The move can come before the access (pre-increment) or after it (post-increment, post-decrement). Because the pointer wraps within 21 bits, a walk through the whole memory space needs no special handling at either end.

A read occupies two cycles, and a busy flag covers both of them. The memory is a synchronous ROM. It registers its output one clock after it sees the read strobe.

Top module: `tblrd_unit`

## Requirements
- R1: During and right after a synchronous reset, the pointer reads 0, the latch reads 0, and busy and the memory read strobe are low.
- R2: When idle and no command is presented, a write with select 0 loads pointer bits [7:0], select 1 loads bits [15:8], and select 2 loads bits [20:16] from data bits [4:0]. Data bits [7:5] of an upper write are dropped, and select 3 changes nothing. The new value appears on the pointer output the next cycle.
- R3: A command presented while idle is accepted on that clock edge. In the following cycle only, the read strobe is high and the word address equals bits [20:1] of the effective byte address.
- R4: Busy is high for exactly the two cycles after acceptance. The latch changes only on the edge that ends busy, and it holds its value at all other times.
- R5: Bit 0 of the effective address picks the byte. 0 takes word bits [7:0], and 1 takes word bits [15:8].
- R6: The adjust codes are 0 = unchanged, 1 = post-increment, 2 = post-decrement and 3 = pre-increment. Each step is 1. The adjusted pointer appears in the cycle after acceptance.
- R7: Pre-increment reads from the incremented pointer. The other three codes read from the pointer as it was before the command.
- R8: Pointer arithmetic wraps modulo 2^21: 0x1FFFFF plus 1 gives 0, and 0 minus 1 gives 0x1FFFFF.
- R9: While busy, commands and pointer writes are ignored. They neither start a read nor change the pointer.
- R10: When a command and a pointer write arrive in the same idle cycle, the command is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ptr_wr_i | input | 1 | Pointer byte write strobe |
| ptr_sel_i | input | 2 | Pointer piece select (0 low, 1 high, 2 upper) |
| ptr_data_i | input | 8 | Pointer write data |
| cmd_valid_i | input | 1 | Table-read command request |
| cmd_mode_i | input | 2 | Pointer adjust code |
| busy_o | output | 1 | Read in progress |
| ptr_o | output | 21 | Current byte pointer |
| latch_o | output | 8 | Byte transfer latch |
| mem_rd_o | output | 1 | Program memory read strobe |
| mem_addr_o | output | 20 | Program memory word address |
| mem_rdata_i | input | 16 | Word from memory, valid one clock after the strobe |

## Verification
The assertions take three things for granted. The memory returns its word exactly one clock after the strobe, the adjust code is meaningful only while the command request is high, and reset is held for at least one edge. The bench ROM registers its output on the strobe, so it meets the one-clock latency by construction. All inputs are driven on the falling edge from a fixed seed. Extra commands and writes are held active during busy cycles, and collisions are produced on purpose, so the ignore and priority rules are exercised at the ports rather than assumed.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;

    // pointer adjust codes carried by a table-read command
    typedef enum logic [1:0] {
        TR_HOLD    = 2'd0,
        TR_POSTINC = 2'd1,
        TR_POSTDEC = 2'd2,
        TR_PREINC  = 2'd3
    } tr_mode_e;

    // sequencer phases
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ISSUE   = 2'd1,
        PH_CAPTURE = 2'd2
    } tr_phase_e;

    // pointer piece selects
    localparam logic [1:0] PSEL_LO = 2'd0;
    localparam logic [1:0] PSEL_HI = 2'd1;
    localparam logic [1:0] PSEL_UP = 2'd2;

    // decoded pointer movement
    typedef struct packed {
        logic move;   // pointer changes by one
        logic down;   // direction is decrement
        logic pre;    // access uses the moved pointer
    } tr_step_t;

    function automatic tr_step_t tr_decode(tr_mode_e m);
        tr_step_t s;
        case (m)
            TR_HOLD:    s = '{move: 1'b0, down: 1'b0, pre: 1'b0};
            TR_POSTINC: s = '{move: 1'b1, down: 1'b0, pre: 1'b0};
            TR_POSTDEC: s = '{move: 1'b1, down: 1'b1, pre: 1'b0};
            TR_PREINC:  s = '{move: 1'b1, down: 1'b0, pre: 1'b1};
            default:    s = '{move: 1'b0, down: 1'b0, pre: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tblrd_ptr_regs.sv
module tblrd_ptr_regs
    import tblrd_pkg::*;
#(
    parameter int PTR_W  = 21,
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [1:0]        sel_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              adv_i,
    input  tr_step_t          step_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [PTR_W-1:0]  eff_o
);
    localparam int UP_W = PTR_W - 2 * BYTE_W;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;

    assign ptr_inc = ptr_q + PTR_W'(1);
    assign ptr_dec = ptr_q - PTR_W'(1);
    assign eff_o   = step_i.pre ? ptr_inc : ptr_q;
    assign ptr_o   = ptr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ptr_q <= '0;
        end else if (adv_i) begin
            if (step_i.move)
                ptr_q <= step_i.down ? ptr_dec : ptr_inc;
        end else if (wr_i) begin
            case (sel_i)
                PSEL_LO: ptr_q[BYTE_W-1:0]        <= data_i;
                PSEL_HI: ptr_q[2*BYTE_W-1:BYTE_W] <= data_i;
                PSEL_UP: ptr_q[PTR_W-1:2*BYTE_W]  <= data_i[UP_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq
    import tblrd_pkg::*;
#(
    parameter int PTR_W = 21
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cmd_valid_i,
    input  logic [PTR_W-1:0] eff_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             mem_rd_o,
    output logic [PTR_W-2:0] mem_addr_o,
    output logic             byte_hi_o,
    output logic             load_o
);
    tr_phase_e        phase_q;
    logic [PTR_W-2:0] addr_q;
    logic             hi_q;

    assign accept_o   = (phase_q == PH_IDLE) && cmd_valid_i;
    assign busy_o     = (phase_q != PH_IDLE);
    assign mem_rd_o   = (phase_q == PH_ISSUE);
    assign load_o     = (phase_q == PH_CAPTURE);
    assign mem_addr_o = addr_q;
    assign byte_hi_o  = hi_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_IDLE;
            addr_q  <= '0;
            hi_q    <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: if (cmd_valid_i) begin
                    phase_q <= PH_ISSUE;
                    addr_q  <= eff_i[PTR_W-1:1];
                    hi_q    <= eff_i[0];
                end
                PH_ISSUE:   phase_q <= PH_CAPTURE;
                PH_CAPTURE: phase_q <= PH_IDLE;
                default:    phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tblrd_byte_sel.sv
module tblrd_byte_sel #(
    parameter int BYTE_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                load_i,
    input  logic                hi_i,
    input  logic [2*BYTE_W-1:0] word_i,
    output logic [BYTE_W-1:0]   latch_o
);
    localparam int LANES = 2;

    logic [BYTE_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            latch_o <= '0;
        else if (load_i)
            latch_o <= lane[hi_i];
    end
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
    import tblrd_pkg::*;
#(
    parameter int PTR_W  = 21,
    parameter int BYTE_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                ptr_wr_i,
    input  logic [1:0]          ptr_sel_i,
    input  logic [BYTE_W-1:0]   ptr_data_i,
    input  logic                cmd_valid_i,
    input  logic [1:0]          cmd_mode_i,
    output logic                busy_o,
    output logic [PTR_W-1:0]    ptr_o,
    output logic [BYTE_W-1:0]   latch_o,
    output logic                mem_rd_o,
    output logic [PTR_W-2:0]    mem_addr_o,
    input  logic [2*BYTE_W-1:0] mem_rdata_i
);
    tr_step_t         step;
    logic [PTR_W-1:0] eff;
    logic             accept;
    logic             wr_ok;
    logic             byte_hi;
    logic             load;

    assign step  = tr_decode(tr_mode_e'(cmd_mode_i));
    // writes only land when idle and no command competes
    assign wr_ok = ptr_wr_i && !busy_o && !cmd_valid_i;

    tblrd_ptr_regs #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) ptr_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .wr_i   (wr_ok),
        .sel_i  (ptr_sel_i),
        .data_i (ptr_data_i),
        .adv_i  (accept),
        .step_i (step),
        .ptr_o  (ptr_o),
        .eff_o  (eff)
    );

    tblrd_seq #(.PTR_W(PTR_W)) seq_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cmd_valid_i (cmd_valid_i),
        .eff_i       (eff),
        .accept_o    (accept),
        .busy_o      (busy_o),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .byte_hi_o   (byte_hi),
        .load_o      (load)
    );

    tblrd_byte_sel #(.BYTE_W(BYTE_W)) sel_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (load),
        .hi_i    (byte_hi),
        .word_i  (mem_rdata_i),
        .latch_o (latch_o)
    );
endmodule

// File: rtl/tblrd_unit_chk.sv
module tblrd_unit_chk #(
    parameter int PTR_W  = 21,
    parameter int BYTE_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              cmd_valid_i,
    input logic [1:0]        cmd_mode_i,
    input logic              busy_o,
    input logic              mem_rd_o,
    input logic [PTR_W-1:0]  ptr_o,
    input logic [BYTE_W-1:0] latch_o
);
    assert_reset_idle_R1: assert property (@(posedge clk_i)
        rst_i |=> (!busy_o && !mem_rd_o && ptr_o == '0 && latch_o == '0));

    assert_start_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_valid_i && !busy_o) |=> (busy_o && mem_rd_o));

    assert_strobe_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_rd_o |=> !mem_rd_o);

    assert_busy_second_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_rd_o |=> busy_o);

    assert_busy_ends_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !mem_rd_o) |=> !busy_o);

    assert_latch_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |=> $stable(latch_o));

    assert_postinc_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_valid_i && !busy_o && cmd_mode_i == 2'd1) |=> (ptr_o == $past(ptr_o) + PTR_W'(1)));

    assert_postdec_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_valid_i && !busy_o && cmd_mode_i == 2'd2) |=> (ptr_o == $past(ptr_o) - PTR_W'(1)));

    assert_ptr_frozen_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |=> $stable(ptr_o));
endmodule

bind tblrd_unit tblrd_unit_chk #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_mode_i  (cmd_mode_i),
    .busy_o      (busy_o),
    .mem_rd_o    (mem_rd_o),
    .ptr_o       (ptr_o),
    .latch_o     (latch_o)
);

// File: tb/tblrd_unit_tb_top.sv
module tblrd_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 21;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ptr_wr = 1'b0;
    logic [1:0]    ptr_sel = 2'd0;
    logic [BW-1:0] ptr_data = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_mode = 2'd0;
    logic          busy;
    logic [PW-1:0] ptr;
    logic [BW-1:0] latch;
    logic          mem_rd;
    logic [PW-2:0] mem_addr;
    logic [2*BW-1:0] rom_q = '0;

    int n_run = 0;
    int n_fail = 0;
    logic [PW-1:0] m_ptr = '0;
    logic [BW-1:0] m_latch = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tblrd_unit dut_i (
        .clk_i(clk), .rst_i(rst), .ptr_wr_i(ptr_wr), .ptr_sel_i(ptr_sel),
        .ptr_data_i(ptr_data), .cmd_valid_i(cmd_valid), .cmd_mode_i(cmd_mode),
        .busy_o(busy), .ptr_o(ptr), .latch_o(latch), .mem_rd_o(mem_rd),
        .mem_addr_o(mem_addr), .mem_rdata_i(rom_q)
    );

    function automatic logic [2*BW-1:0] rom_word(logic [PW-2:0] a);
        return {a[7:0] ^ 8'hC3, a[15:8] + {4'h0, a[19:16]} + 8'h11};
    endfunction

    always_ff @(posedge clk) if (mem_rd) rom_q <= rom_word(mem_addr);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_byte(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        ptr_wr = 1'b1; ptr_sel = sel; ptr_data = d;
        @(negedge clk);
        ptr_wr = 1'b0;
        case (sel)
            2'd0: m_ptr[7:0]   = d;
            2'd1: m_ptr[15:8]  = d;
            2'd2: m_ptr[20:16] = d[4:0];
            default: ;
        endcase
        chk("R2 ptr after write", 32'(ptr), 32'(m_ptr));
    endtask

    task automatic do_read(logic [1:0] mode, bit with_wr, bit poke);
        logic [PW-1:0] eff;
        logic [PW-1:0] nxt;
        logic [2*BW-1:0] w;
        eff = (mode == 2'd3) ? m_ptr + PW'(1) : m_ptr;
        case (mode)
            2'd0: nxt = m_ptr;
            2'd2: nxt = m_ptr - PW'(1);
            default: nxt = m_ptr + PW'(1);
        endcase
        w = rom_word(eff[PW-1:1]);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = mode;
        if (with_wr) begin
            ptr_wr = 1'b1; ptr_sel = 2'd0; ptr_data = ~m_ptr[7:0];
        end
        @(negedge clk);
        cmd_valid = 1'b0; ptr_wr = 1'b0;
        chk("R4 busy first cycle", 32'(busy), 32'd1);
        chk("R3 strobe high", 32'(mem_rd), 32'd1);
        chk("R7 word address", 32'(mem_addr), 32'(eff[PW-1:1]));
        chk(with_wr ? "R10 command wins over write" : "R6/R8 adjusted ptr", 32'(ptr), 32'(nxt));
        chk("R4 latch holds while busy", 32'(latch), 32'(m_latch));
        if (poke) begin
            cmd_valid = 1'b1; cmd_mode = 2'd1;
            ptr_wr = 1'b1; ptr_sel = 2'($urandom % 3); ptr_data = 8'($urandom);
        end
        @(negedge clk);
        chk("R4 busy second cycle", 32'(busy), 32'd1);
        chk("R3 strobe single", 32'(mem_rd), 32'd0);
        @(negedge clk);
        cmd_valid = 1'b0; ptr_wr = 1'b0;
        m_latch = eff[0] ? w[15:8] : w[7:0];
        chk("R4 busy drops", 32'(busy), 32'd0);
        chk("R5 latched byte", 32'(latch), 32'(m_latch));
        chk("R9 ptr frozen while busy", 32'(ptr), 32'(nxt));
        m_ptr = nxt;
        if (poke) begin
            @(negedge clk);
            chk("R9 ignored command started nothing", 32'({busy, mem_rd}), 32'd0);
            chk("R9 ignored write", 32'(ptr), 32'(m_ptr));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL R4 watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 ptr in reset", 32'(ptr), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ptr", 32'(ptr), 32'd0);
        chk("R1 latch", 32'(latch), 32'd0);
        chk("R1 busy/strobe", 32'({busy, mem_rd}), 32'd0);

        // pointer pieces, upper bits dropped, select 3 ignored
        put_byte(2'd0, 8'h34);
        put_byte(2'd1, 8'h12);
        put_byte(2'd2, 8'hE5);
        put_byte(2'd3, 8'hAA);

        // byte selection both halves
        do_read(2'd0, 1'b0, 1'b0);
        put_byte(2'd0, 8'h35);
        do_read(2'd0, 1'b0, 1'b0);

        // wrap upward and downward
        put_byte(2'd2, 8'h1F); put_byte(2'd1, 8'hFF); put_byte(2'd0, 8'hFF);
        do_read(2'd1, 1'b0, 1'b0);
        chk("R8 wrap to zero", 32'(ptr), 32'd0);
        do_read(2'd2, 1'b0, 1'b0);
        chk("R8 wrap to top", 32'(ptr), 32'h1FFFFF);
        do_read(2'd3, 1'b0, 1'b0);
        chk("R7 pre-increment wrapped read", 32'(ptr), 32'd0);

        // collision and busy pokes
        do_read(2'd1, 1'b1, 1'b0);
        do_read(2'd0, 1'b1, 1'b0);
        do_read(2'd2, 1'b0, 1'b1);
        do_read(2'd3, 1'b1, 1'b1);

        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            r = $urandom % 8;
            if (r < 2)
                put_byte(2'($urandom % 4), 8'($urandom));
            else
                do_read(2'($urandom % 4), ($urandom % 6) == 0, ($urandom % 4) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule